// File: doc/BRIEF.md
# Halfword-Stream Instruction Format Decoder

This block sits behind an instruction fetch path and turns a stream of 16-bit halfwords into one decoded format record per instruction. It reads the first halfword to find the form class. A form whose top nibble is 1111 takes a second base halfword. A two-bit size code in the 1110 and 1111 forms, or the form itself for the offset-carrying short forms, says how many extension halfwords follow. Those halfwords are gathered least significant first and sign-extended to 64 bits.

The record gives the form class, the total length, the extension size code, the size/domain code, the effective-address mode, the opcode bits, the three register fields and the decoded quick values. The quick values are the signed 4-bit value, that value scaled to an offset, the 1..16 scale and the signed 8-bit value. Three flags mark LEA, reserved encodings and illegal nonzero fields. The record is registered and appears for one cycle after the last halfword of its instruction is accepted. Execution, register access and memory fetch are outside the block.

Top module: `ifd_top`

## Requirements
- R1: `out_len` equals the base length plus the number of extension halfwords. The base length is 2 halfwords when bits 15:12 of the first halfword are 1111 and 1 halfword otherwise.
- R2: A halfword is taken on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` is high for exactly the one cycle after the edge that takes the last halfword of an instruction, so there is exactly one record per instruction.
- R3: For first-halfword bits 15:12 equal to 1110 or 1111, `out_xx` is bits 11:10, and 00/01/10/11 mean 0/1/2/4 extension halfwords. When bits 15:13 are 011, 100 or 101, or bits 15:12 are 1100 or 1101, `out_xx` is 01 and one halfword follows. In every other case `out_xx` is 00.
- R4: The first extension halfword supplies bits 15:0 of the value, the next supplies bits 31:16, and so on. `out_ext` is that value sign-extended from 16, 32 or 64 bits, and it is 0 when no extension is present.
- R5: `out_form` is 0 for top bits 000, 1 for 0010, 2 for 0011, 3 for 010, 4 for 011, 5 for 100, 6 for 101, 7 for 1100, 8 for 1101, 9 for 1110 and 10 for 1111.
- R6: `out_dom` is bits 6:4 of the first halfword in the 1111 form and 100 (pointer) in the 1110 form. In all other forms it is {0, bits 9:8}.
- R7: The quick nibble is bits 11:8 of the second halfword in the 1111 form and bits 7:4 of the first halfword otherwise. `out_q4` is that nibble as two's complement, except that 0000 gives +8, so the value is never 0.
- R8: `out_q4_off` is `out_q4` multiplied by the byte size of `out_dom`. The byte sizes for domains 000..111 are 1, 2, 4, 8, PTR_BYTES (default 8), 16, 32 and 64.
- R9: `out_scale` is the quick nibble read as unsigned, with 0000 giving 16.
- R10: In the 1111 form, `out_q8` is bits 15:8 of the second halfword sign-extended and never scaled. In other forms it is 0.
- R11: `out_rd` is bits 3:0 of the first halfword. In the 1111 form, `out_rs` is bits 15:12 of the second halfword, `out_rg` is bits 7:4 of the second halfword, and `out_eee` is {first[9:8], first[7]}. In other forms `out_rs` is first[7:4], and `out_rg` and `out_eee` are 0.
- R12: In the 1111 form, `out_op` is {1111, second[3:0]} when eee is 110 or 111 and second[7:0] otherwise. `out_lea` is set for eee 110 with second[3:0] equal to 1111, and `out_rsvd` is set for eee 111 with second[3:0] equal to 1111. Short forms with a 3-bit opcode (top bits 000, 010, 011, 100, 101) give first[12:10]. Short forms with a 2-bit opcode (0010, 0011, 1100, 1101) give first[11:10]. The 1110 form gives {00, first[9:8], first[7:4]}.
- R13: `out_illegal` is set only in the 1111 form when eee is 001, 100 or 101, xx is not 00 and second[11:8] is nonzero.
- R14: While `rst` is high, `out_valid` and `in_ready` are low. From the first edge after reset, `in_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Halfword present |
| in_ready | output | 1 | Block can take a halfword |
| in_data | input | 16 | Instruction halfword |
| out_valid | output | 1 | Record valid for one cycle |
| out_form | output | 4 | Form class code |
| out_len | output | 3 | Total length in halfwords |
| out_xx | output | 2 | Extension size code |
| out_eee | output | 3 | Effective-address mode (long form) |
| out_dom | output | 3 | Operation size / register domain |
| out_op | output | 8 | Opcode bits |
| out_rd | output | 4 | Destination register field |
| out_rs | output | 4 | Source register field |
| out_rg | output | 4 | Index register field |
| out_q4 | output | 5 | Signed 4-bit quick value (-8..+8) |
| out_q4_off | output | 16 | Quick value scaled by operand bytes |
| out_scale | output | 5 | Unsigned scale 1..16 |
| out_q8 | output | 16 | Sign-extended 8-bit quick value |
| out_ext | output | 64 | Sign-extended extension value |
| out_illegal | output | 1 | Must-be-zero field is nonzero |
| out_lea | output | 1 | Scaled-mode LEA encoding |
| out_rsvd | output | 1 | Reserved scaled-mode encoding |

## Verification
The bench aims at the quick nibble 0000. A decoder that treats it as zero would report 0 for the immediate and the scale instead of +8 and 16, and scaling it in the 512-bit domain would give 0 instead of 512. Long instructions with 64-bit negative extensions and 1110 forms with 32-bit ones catch lanes placed in the wrong order or sign-extended from the wrong width. Random gaps in `in_valid` between halfwords catch a sequencer that counts idle cycles as data. A sequencer that misjudges the length would raise the record on the wrong cycle or swallow the next instruction's first halfword. Directed LEA, reserved and illegal encodings check that each flag is raised only for its own combination of mode, opcode and quick field.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

  localparam int HALF_W    = 16;
  localparam int EXT_LANES = 4;
  localparam int EXT_W     = HALF_W * EXT_LANES;

  typedef enum logic [3:0] {
    FC_RR   = 4'd0,
    FC_RP   = 4'd1,
    FC_QP   = 4'd2,
    FC_QR   = 4'd3,
    FC_QM   = 4'd4,
    FC_RM   = 4'd5,
    FC_MR   = 4'd6,
    FC_PM   = 4'd7,
    FC_MP   = 4'd8,
    FC_EA   = 4'd9,
    FC_LONG = 4'd10
  } form_e;

  typedef struct packed {
    form_e       form;
    logic [1:0]  xx;
    logic [2:0]  eee;
    logic [2:0]  dom;
    logic [7:0]  op;
    logic [3:0]  rd;
    logic [3:0]  rs;
    logic [3:0]  rg;
    logic [3:0]  nib;
    logic [7:0]  q8raw;
    logic        lea;
    logic        rsvd;
    logic        illegal;
  } fmt_t;

  // extension halfword count for a size code
  function automatic logic [2:0] ext_halves(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd0;
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ifd_fmt_decode.sv
module ifd_fmt_decode
  import ifd_pkg::*;
(
  input  logic [HALF_W-1:0] w0,
  input  logic [HALF_W-1:0] w1,
  output fmt_t              fmt
);

  logic long_f;
  logic [2:0] mode;

  always_comb begin
    long_f = (w0[15:12] == 4'hF);
    mode   = {w0[9:8], w0[7]};

    fmt         = '0;
    fmt.rd      = w0[3:0];
    fmt.rs      = long_f ? w1[15:12] : w0[7:4];
    fmt.rg      = long_f ? w1[7:4]   : 4'h0;
    fmt.nib     = long_f ? w1[11:8]  : w0[7:4];
    fmt.q8raw   = w1[15:8];
    fmt.dom     = {1'b0, w0[9:8]};

    casez (w0[15:12])
      4'b000?: begin fmt.form = FC_RR; fmt.op = {5'b0, w0[12:10]}; end
      4'b0010: begin fmt.form = FC_RP; fmt.op = {6'b0, w0[11:10]}; end
      4'b0011: begin fmt.form = FC_QP; fmt.op = {6'b0, w0[11:10]}; end
      4'b010?: begin fmt.form = FC_QR; fmt.op = {5'b0, w0[12:10]}; end
      4'b011?: begin fmt.form = FC_QM; fmt.op = {5'b0, w0[12:10]}; fmt.xx = 2'b01; end
      4'b100?: begin fmt.form = FC_RM; fmt.op = {5'b0, w0[12:10]}; fmt.xx = 2'b01; end
      4'b101?: begin fmt.form = FC_MR; fmt.op = {5'b0, w0[12:10]}; fmt.xx = 2'b01; end
      4'b1100: begin fmt.form = FC_PM; fmt.op = {6'b0, w0[11:10]}; fmt.xx = 2'b01; end
      4'b1101: begin fmt.form = FC_MP; fmt.op = {6'b0, w0[11:10]}; fmt.xx = 2'b01; end
      4'b1110: begin
        fmt.form = FC_EA;
        fmt.xx   = w0[11:10];
        fmt.dom  = 3'b100;
        fmt.op   = {2'b00, w0[9:8], w0[7:4]};
      end
      default: begin
        fmt.form = FC_LONG;
        fmt.xx   = w0[11:10];
        fmt.eee  = mode;
        fmt.dom  = w0[6:4];
        fmt.op   = mode[2:1] == 2'b11 ? {4'hF, w1[3:0]} : w1[7:0];
        fmt.lea  = (mode == 3'b110) && (w1[3:0] == 4'hF);
        fmt.rsvd = (mode == 3'b111) && (w1[3:0] == 4'hF);
        fmt.illegal = ((mode == 3'b001) || (mode == 3'b100) || (mode == 3'b101))
                      && (w0[11:10] != 2'b00) && (w1[11:8] != 4'h0);
      end
    endcase
  end

endmodule

// File: rtl/ifd_quick.sv
module ifd_quick #(
  parameter int PTR_BYTES = 8,
  parameter int OFF_W     = 16
) (
  input  logic [3:0]        nib,
  input  logic [2:0]        dom,
  input  logic [7:0]        q8_raw,
  input  logic              use_q8,
  output logic signed [4:0] q4,
  output logic [OFF_W-1:0]  q4_off,
  output logic [4:0]        scale,
  output logic [OFF_W-1:0]  q8
);

  localparam logic [6:0] PB = 7'(PTR_BYTES);

  logic [6:0]              nbytes;
  logic signed [OFF_W-1:0] q4_wide;
  logic signed [OFF_W-1:0] nb_wide;
  logic signed [OFF_W-1:0] prod;

  always_comb begin
    case (dom)
      3'd0:    nbytes = 7'd1;
      3'd1:    nbytes = 7'd2;
      3'd2:    nbytes = 7'd4;
      3'd3:    nbytes = 7'd8;
      3'd4:    nbytes = PB;
      3'd5:    nbytes = 7'd16;
      3'd6:    nbytes = 7'd32;
      default: nbytes = 7'd64;
    endcase
  end

  always_comb begin
    q4      = (nib == 4'h0) ? 5'sd8 : $signed({nib[3], nib});
    scale   = (nib == 4'h0) ? 5'd16 : {1'b0, nib};
    q4_wide = OFF_W'(q4);
    nb_wide = $signed({{(OFF_W-7){1'b0}}, nbytes});
    prod    = q4_wide * nb_wide;
    q4_off  = prod;
    q8      = use_q8 ? {{(OFF_W-8){q8_raw[7]}}, q8_raw} : '0;
  end

endmodule

// File: rtl/ifd_ext_collect.sv
module ifd_ext_collect
  import ifd_pkg::*;
#(
  parameter int LANE_W = $clog2(EXT_LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [HALF_W-1:0] din,
  input  logic [1:0]        xx,
  output logic [EXT_W-1:0]  ext_out
);

  logic [EXT_LANES-1:0][HALF_W-1:0] lane_q;
  logic [EXT_LANES-1:0][HALF_W-1:0] lane_n;
  logic [EXT_W-1:0]                 raw;

  always_comb begin
    for (int g = 0; g < EXT_LANES; g++) begin
      if (wr_en && (wr_lane == LANE_W'(g)))
        lane_n[g] = din;
      else if (start)
        lane_n[g] = '0;
      else
        lane_n[g] = lane_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lane_q <= '0;
    else     lane_q <= lane_n;
  end

  assign raw = lane_n;

  always_comb begin
    case (xx)
      2'b00:   ext_out = '0;
      2'b01:   ext_out = {{(EXT_W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
      2'b10:   ext_out = {{(EXT_W-2*HALF_W){raw[2*HALF_W-1]}}, raw[2*HALF_W-1:0]};
      default: ext_out = raw;
    endcase
  end

endmodule

// File: rtl/ifd_top.sv
module ifd_top
  import ifd_pkg::*;
#(
  parameter int PTR_BYTES = 8,
  parameter int OFF_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_data,
  output logic              out_valid,
  output logic [3:0]        out_form,
  output logic [2:0]        out_len,
  output logic [1:0]        out_xx,
  output logic [2:0]        out_eee,
  output logic [2:0]        out_dom,
  output logic [7:0]        out_op,
  output logic [3:0]        out_rd,
  output logic [3:0]        out_rs,
  output logic [3:0]        out_rg,
  output logic [4:0]        out_q4,
  output logic [OFF_W-1:0]  out_q4_off,
  output logic [4:0]        out_scale,
  output logic [OFF_W-1:0]  out_q8,
  output logic [63:0]       out_ext,
  output logic              out_illegal,
  output logic              out_lea,
  output logic              out_rsvd
);

  localparam int LANE_W = $clog2(EXT_LANES);

  typedef enum logic [1:0] {ST_W0, ST_W1, ST_EXT} seq_e;

  seq_e              st, st_n;
  logic [HALF_W-1:0] w0_q, w1_q, w0_n, w1_n;
  logic [LANE_W-1:0] lane_idx, idx_n;
  logic              rdy_q, acc, emit, is_long;
  logic [2:0]        nx;
  fmt_t              fmt;
  logic [EXT_W-1:0]  ext_n;
  logic signed [4:0] q4_n;
  logic [OFF_W-1:0]  q4_off_n, q8_n;
  logic [4:0]        scale_n;

  assign acc      = in_valid && rdy_q;
  assign in_ready = rdy_q;

  // halfword currently on the bus stands in for the register it will fill
  assign w0_n = (st == ST_W0) ? in_data : w0_q;
  assign w1_n = (st == ST_W1) ? in_data : ((st == ST_W0) ? '0 : w1_q);

  ifd_fmt_decode u_dec (
    .w0  (w0_n),
    .w1  (w1_n),
    .fmt (fmt)
  );

  assign is_long = (fmt.form == FC_LONG);
  assign nx      = ext_halves(fmt.xx);

  ifd_ext_collect #(.LANE_W(LANE_W)) u_ext (
    .clk     (clk),
    .rst     (rst),
    .start   (acc && (st == ST_W0)),
    .wr_en   (acc && (st == ST_EXT)),
    .wr_lane (lane_idx),
    .din     (in_data),
    .xx      (fmt.xx),
    .ext_out (ext_n)
  );

  ifd_quick #(.PTR_BYTES(PTR_BYTES), .OFF_W(OFF_W)) u_quick (
    .nib    (fmt.nib),
    .dom    (fmt.dom),
    .q8_raw (fmt.q8raw),
    .use_q8 (is_long),
    .q4     (q4_n),
    .q4_off (q4_off_n),
    .scale  (scale_n),
    .q8     (q8_n)
  );

  always_comb begin
    emit  = 1'b0;
    st_n  = st;
    idx_n = lane_idx;
    if (acc) begin
      case (st)
        ST_W0: begin
          if (is_long)        st_n = ST_W1;
          else if (nx == 3'd0) emit = 1'b1;
          else begin st_n = ST_EXT; idx_n = '0; end
        end
        ST_W1: begin
          if (nx == 3'd0) begin emit = 1'b1; st_n = ST_W0; end
          else begin st_n = ST_EXT; idx_n = '0; end
        end
        ST_EXT: begin
          if ({1'b0, lane_idx} == nx - 3'd1) begin emit = 1'b1; st_n = ST_W0; end
          else idx_n = lane_idx + 1'b1;
        end
        default: st_n = ST_W0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_W0;
      w0_q      <= '0;
      w1_q      <= '0;
      lane_idx  <= '0;
      rdy_q     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      rdy_q     <= 1'b1;
      out_valid <= emit;
      st        <= st_n;
      lane_idx  <= idx_n;
      if (acc && st == ST_W0) begin w0_q <= in_data; w1_q <= '0; end
      if (acc && st == ST_W1) w1_q <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_form <= '0; out_len <= '0; out_xx <= '0; out_eee <= '0;
      out_dom <= '0; out_op <= '0; out_rd <= '0; out_rs <= '0; out_rg <= '0;
      out_q4 <= '0; out_q4_off <= '0; out_scale <= '0; out_q8 <= '0;
      out_ext <= '0; out_illegal <= 1'b0; out_lea <= 1'b0; out_rsvd <= 1'b0;
    end else if (emit) begin
      out_form    <= fmt.form;
      out_len     <= (is_long ? 3'd2 : 3'd1) + nx;
      out_xx      <= fmt.xx;
      out_eee     <= fmt.eee;
      out_dom     <= fmt.dom;
      out_op      <= fmt.op;
      out_rd      <= fmt.rd;
      out_rs      <= fmt.rs;
      out_rg      <= fmt.rg;
      out_q4      <= q4_n;
      out_q4_off  <= q4_off_n;
      out_scale   <= scale_n;
      out_q8      <= q8_n;
      out_ext     <= ext_n;
      out_illegal <= fmt.illegal;
      out_lea     <= fmt.lea;
      out_rsvd    <= fmt.rsvd;
    end
  end

  p_len_bound_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd6));
  p_long_len_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_form == 4'(FC_LONG)) |-> out_len >= 3'd2);
  p_ext16_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_xx == 2'b01) |-> out_ext[63:16] == {48{out_ext[15]}});
  p_noext_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_xx == 2'b00) |-> out_ext == 64'd0);
  p_q4_nozero_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_q4 != 5'd0);
  p_scale_span_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_scale != 5'd0 && out_scale <= 5'd16));
  p_flag_excl_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({out_lea, out_rsvd}));
  p_illegal_long_r13: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_form == 4'(FC_LONG) && out_xx != 2'b00));
  p_ready_hold_r14: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

endmodule

// File: tb/sim_ifd_top.sv
`timescale 1ns/1ps
module sim_ifd_top;

  typedef struct packed {
    logic [3:0]  form;
    logic [2:0]  len;
    logic [1:0]  xx;
    logic [2:0]  eee;
    logic [2:0]  dom;
    logic [7:0]  op;
    logic [3:0]  rd, rs, rg;
    logic [4:0]  q4;
    logic [15:0] qoff;
    logic [4:0]  scale;
    logic [15:0] q8;
    logic [63:0] ext;
    logic        ill, lea, rsv;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid, out_illegal, out_lea, out_rsvd;
  logic [3:0] out_form, out_rd, out_rs, out_rg;
  logic [2:0] out_len, out_eee, out_dom;
  logic [1:0] out_xx;
  logic [7:0] out_op;
  logic [4:0] out_q4, out_scale;
  logic [15:0] out_q4_off, out_q8;
  logic [63:0] out_ext;

  int total = 0, bad = 0, wr_i = 0, rd_i = 0;
  bit done = 0;
  exp_t exp_mem [0:1023];

  always #2.5 clk = ~clk;

  ifd_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_form(out_form), .out_len(out_len), .out_xx(out_xx),
    .out_eee(out_eee), .out_dom(out_dom), .out_op(out_op), .out_rd(out_rd),
    .out_rs(out_rs), .out_rg(out_rg), .out_q4(out_q4), .out_q4_off(out_q4_off),
    .out_scale(out_scale), .out_q8(out_q8), .out_ext(out_ext),
    .out_illegal(out_illegal), .out_lea(out_lea), .out_rsvd(out_rsvd)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exv);
    total++;
    if (act !== exv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exv);
    end
  endtask

  function automatic exp_t model(input logic [15:0] w0, input logic [15:0] w1i, input logic [63:0] e);
    exp_t x;
    logic [15:0] w1;
    logic lg;
    int q, nb, h;
    logic [3:0] nib;
    x  = '0;
    lg = (w0[15:12] == 4'hF);
    w1 = lg ? w1i : 16'h0;
    h  = 0;
    x.dom = {1'b0, w0[9:8]};
    if (lg) begin
      x.form = 4'd10; x.xx = w0[11:10]; x.eee = {w0[9:8], w0[7]}; x.dom = w0[6:4];
      x.op = (x.eee >= 3'd6) ? {4'hF, w1[3:0]} : w1[7:0];
      x.lea = (x.eee == 3'd6) && (w1[3:0] == 4'hF);
      x.rsv = (x.eee == 3'd7) && (w1[3:0] == 4'hF);
      x.ill = (x.eee == 3'd1 || x.eee == 3'd4 || x.eee == 3'd5) && (x.xx != 0) && (w1[11:8] != 0);
    end else if (w0[15:12] == 4'hE) begin
      x.form = 4'd9; x.xx = w0[11:10]; x.dom = 3'd4; x.op = {2'b00, w0[9:8], w0[7:4]};
    end else if (w0[15:12] == 4'hD) begin x.form = 4'd8; x.xx = 1; x.op = {6'b0, w0[11:10]};
    end else if (w0[15:12] == 4'hC) begin x.form = 4'd7; x.xx = 1; x.op = {6'b0, w0[11:10]};
    end else if (w0[15:13] == 3'b101) begin x.form = 4'd6; x.xx = 1; x.op = {5'b0, w0[12:10]};
    end else if (w0[15:13] == 3'b100) begin x.form = 4'd5; x.xx = 1; x.op = {5'b0, w0[12:10]};
    end else if (w0[15:13] == 3'b011) begin x.form = 4'd4; x.xx = 1; x.op = {5'b0, w0[12:10]};
    end else if (w0[15:13] == 3'b010) begin x.form = 4'd3; x.op = {5'b0, w0[12:10]};
    end else if (w0[15:12] == 4'b0011) begin x.form = 4'd2; x.op = {6'b0, w0[11:10]};
    end else if (w0[15:12] == 4'b0010) begin x.form = 4'd1; x.op = {6'b0, w0[11:10]};
    end else begin x.form = 4'd0; x.op = {5'b0, w0[12:10]}; end
    h = (x.xx == 2'd3) ? 4 : int'(x.xx);
    x.len = 3'((lg ? 2 : 1) + h);
    case (x.xx)
      2'd0: x.ext = 64'd0;
      2'd1: x.ext = {{48{e[15]}}, e[15:0]};
      2'd2: x.ext = {{32{e[31]}}, e[31:0]};
      default: x.ext = e;
    endcase
    case (x.dom)
      3'd0: nb = 1; 3'd1: nb = 2; 3'd2: nb = 4; 3'd3: nb = 8;
      3'd4: nb = 8; 3'd5: nb = 16; 3'd6: nb = 32; default: nb = 64;
    endcase
    nib = lg ? w1[11:8] : w0[7:4];
    q = (nib == 0) ? 8 : ((nib > 7) ? int'(nib) - 16 : int'(nib));
    x.q4 = 5'(q);
    x.qoff = 16'(q * nb);
    x.scale = (nib == 0) ? 5'd16 : {1'b0, nib};
    x.q8 = lg ? {{8{w1[15]}}, w1[15:8]} : 16'h0;
    x.rd = w0[3:0];
    x.rs = lg ? w1[15:12] : w0[7:4];
    x.rg = lg ? w1[7:4] : 4'h0;
    return x;
  endfunction

  // record monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd_i >= wr_i) chk("R2 record without instruction", 64'(rd_i), 64'(wr_i));
      else begin
        exp_t x;
        x = exp_mem[rd_i];
        chk("R5 form", 64'(out_form), 64'(x.form));
        chk("R1 length", 64'(out_len), 64'(x.len));
        chk("R3 ext size", 64'(out_xx), 64'(x.xx));
        chk("R4 ext value", out_ext, x.ext);
        chk("R6 domain", 64'(out_dom), 64'(x.dom));
        chk("R7 quick4", 64'(out_q4), 64'(x.q4));
        chk("R8 quick offset", 64'(out_q4_off), 64'(x.qoff));
        chk("R9 scale", 64'(out_scale), 64'(x.scale));
        chk("R10 quick8", 64'(out_q8), 64'(x.q8));
        chk("R11 regs", 64'({out_rd, out_rs, out_rg, out_eee}), 64'({x.rd, x.rs, x.rg, x.eee}));
        chk("R12 opcode", 64'(out_op), 64'(x.op));
        chk("R12 lea/rsvd", 64'({out_lea, out_rsvd}), 64'({x.lea, x.rsv}));
        chk("R13 illegal", 64'(out_illegal), 64'(x.ill));
        rd_i++;
      end
    end
  end

  task automatic send_half(input logic [15:0] h, input int gap);
    for (int g = 0; g < gap; g++) begin in_valid = 1'b0; @(negedge clk); end
    in_valid = 1'b1; in_data = h;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_insn(input logic [15:0] w0, input logic [15:0] w1, input logic [63:0] e, input bit gaps);
    exp_t x;
    int nh;
    x = model(w0, w1, e);
    exp_mem[wr_i] = x;
    wr_i++;
    nh = int'(x.len) - ((w0[15:12] == 4'hF) ? 2 : 1);
    send_half(w0, gaps ? (($urandom % 4 == 0) ? int'($urandom % 3) : 0) : 0);
    if (w0[15:12] == 4'hF) send_half(w1, gaps ? int'($urandom % 2) : 0);
    for (int k = 0; k < nh; k++) send_half(e[16*k +: 16], gaps ? int'($urandom % 2) : 0);
    chk("R2 record one cycle after last halfword", 64'(out_valid), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R14 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R14 in_ready in reset", 64'(in_ready), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R14 in_ready after reset", 64'(in_ready), 64'd1);

    // directed corners
    send_insn(16'h0000, 16'h0, 64'h0, 0);                      // R7 nibble 0000 -> +8
    send_insn(16'h6705, 16'h0, 64'h0000_0000_0000_8000, 0);    // R3 R4 offset form, negative
    send_insn(16'hF335, 16'h203F, 64'h0, 0);                   // R12 LEA, R9 scale 16
    send_insn(16'hF3B5, 16'h203F, 64'h0, 0);                   // R12 reserved
    send_insn(16'hF621, 16'h1300, 64'h0000_0000_0000_1234, 0); // R13 illegal
    send_insn(16'hF621, 16'h1000, 64'h0000_0000_0000_1234, 0); // R13 legal with vvvv=0
    send_insn(16'hFCF0, 16'h80AA, 64'h8000_0000_0000_0001, 0); // R4 64-bit, R10 -128
    send_insn(16'hE934, 16'h0, 64'h0000_0000_FFFF_FFFE, 0);    // R4 32-bit negative
    send_insn(16'hF270, 16'h0800, 64'h0, 0);                   // R8 -8 * 64 bytes
    send_insn(16'hF270, 16'h0000, 64'h0, 0);                   // R8 +8 * 64 bytes

    for (int n = 0; n < 400; n++) begin
      logic [15:0] a, b;
      logic [63:0] e;
      a = 16'($urandom);
      b = 16'($urandom);
      e = {$urandom, $urandom};
      if ($urandom % 3 == 0) a[15:12] = 4'hF;
      if ($urandom % 2 == 0) b[11:8] = 4'h0;
      send_insn(a, b, e, 1);
    end

    repeat (4) @(negedge clk);
    chk("R2 record count", 64'(rd_i), 64'(wr_i));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule